// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds a set of independent down-counters (eight by default, 32 bits each) behind one small register window. Software loads a start value into a channel's count register, then sets the channel's enable bit and picks one of three behaviours: a free-running count that wraps through zero, a single countdown that stops at zero, or a countdown that reloads itself forever. Each channel owns one interrupt line that pulses for one clock when its count goes from 1 to 0.

The register bus is a plain synchronous access port sharing the timer clock. An access is one cycle with `bus_sel` high; there is no wait state and no back-pressure, so the bus never stalls and every selected cycle completes. Read data is registered and appears on `bus_rdata` in the cycle after the access edge, holding the value the register had just before that edge. Each channel occupies eight bytes: control word first, count word second.

Top module: `tick_bank`

## Requirements
- R1: After reset every channel is disabled in free mode with count and reload value zero, every `irq` bit is low and `bus_rdata` is zero.
- R2: Channel t's control word sits at byte address 8*t and its count word at 8*t+4; addresses with bits [1:0] non-zero are ignored. A control read returns the enable in bit 0 and the mode in bits [5:4], all other bits zero; other written control bits are dropped.
- R3: A count write takes effect only when all four byte strobes are set; a control write needs strobe 0 and is ignored without it.
- R4: A count write sets both the live counter and the channel's reload value; reading the count word returns the live counter.
- R5: While enabled and running, the counter drops by exactly one on each clock edge.
- R6: Mode 1 (single countdown): on the edge where the counter goes 1 to 0 the channel's `irq` is high for exactly one cycle, after which the counter stays at 0 with no further interrupt.
- R7: Mode 2 (reload): on the edge where the counter would go 1 to 0 it instead takes the reload value and `irq` pulses, so an interrupt arrives every N cycles for a reload value N.
- R8: Mode 0 (free run): the counter keeps counting through zero, wrapping from 0 to all ones, and pulses `irq` on each 1 to 0 step only.
- R9: Mode 3 behaves exactly as mode 1.
- R10: Channels are independent: an access to one channel changes no other channel's count, control or interrupt.
- R11: A count write landing on the same edge as a count step wins; if that edge would have been an expiry, no interrupt is raised.
- R12: Clearing the enable bit freezes the counter at its present value until enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per high cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address within the window |
| bus_be | input | CNT_W/8 (4) | Byte-lane write strobes |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Registered read data, valid the cycle after a read |
| irq | output | N_CH (8) | Per-channel expiry pulse |

## Verification
The bench drives each mode from a start value through and past its expiry, then freezes the channel and reads back the count, so a counter that skips the reload, stops too late, refuses to wrap in free mode, or keeps running after enable drops shows a wrong value. It counts interrupt pulses per channel, which exposes a sticky or doubled interrupt, a pulse in free mode on the 0 to all-ones wrap, and a pulse raised when a count write collides with expiry. Partial-strobe writes and collisions between a load and a count step are aimed at designs that accept narrow count writes or let the decrement override the load.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // mode field encodings
  localparam logic [1:0] TM_FREE     = 2'd0;
  localparam logic [1:0] TM_ONCE     = 2'd1;
  localparam logic [1:0] TM_LOOP     = 2'd2;
  localparam logic [1:0] TM_ONCE_ALT = 2'd3;

  // control word layout
  localparam int CTRL_EN_POS   = 0;
  localparam int CTRL_MODE_LSB = 4;

  // per-channel window: 8 bytes, count word at +4
  localparam int STRIDE_LOG2 = 3;
  localparam int WORD_SEL    = 2;
endpackage

// File: rtl/tick_regif.sv
module tick_regif
  import tick_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int CNT_W = 32,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int ADDR_W = CH_W + STRIDE_LOG2,
  localparam int BE_W   = CNT_W / 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BE_W-1:0]            bus_be,
  input  logic [CNT_W-1:0]           bus_wdata,
  output logic [CNT_W-1:0]           bus_rdata,
  output logic [N_CH-1:0]            ctrl_we,
  output logic                       ctrl_en,
  output logic [1:0]                 ctrl_mode,
  output logic [N_CH-1:0]            cnt_we,
  output logic [CNT_W-1:0]           cnt_val,
  input  logic [N_CH-1:0]            rd_en,
  input  logic [N_CH-1:0][1:0]       rd_mode,
  input  logic [N_CH-1:0][CNT_W-1:0] rd_cnt
);

  logic [CH_W-1:0] ch_idx;
  logic            word_hi;
  logic            hit;
  logic [CNT_W-1:0] ctrl_word;

  assign ch_idx  = bus_addr[ADDR_W-1:STRIDE_LOG2];
  assign word_hi = bus_addr[WORD_SEL];
  assign hit     = bus_sel && (bus_addr[1:0] == 2'b00);

  always_comb begin
    ctrl_we = '0;
    cnt_we  = '0;
    if (hit && bus_wr) begin
      if (!word_hi && bus_be[0]) ctrl_we[ch_idx] = 1'b1;
      if (word_hi && (&bus_be))  cnt_we[ch_idx]  = 1'b1;
    end
  end

  assign ctrl_en   = bus_wdata[CTRL_EN_POS];
  assign ctrl_mode = bus_wdata[CTRL_MODE_LSB +: 2];
  assign cnt_val   = bus_wdata;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_POS]         = rd_en[ch_idx];
    ctrl_word[CTRL_MODE_LSB +: 2]  = rd_mode[ch_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (hit && !bus_wr) begin
      bus_rdata <= word_hi ? rd_cnt[ch_idx] : ctrl_word;
    end
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, cnt_we}));

  // R3
  narrow_count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !(&bus_be)) |-> (cnt_we == '0));

endmodule

// File: rtl/tick_chan.sv
module tick_chan
  import tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             ctrl_en,
  input  logic [1:0]       ctrl_mode,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             en_q,
  output logic [1:0]       mode_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;
  logic             running;
  logic             at_one;
  logic             expire;
  logic             loop_mode;

  assign loop_mode = (mode_q == TM_LOOP);
  assign running   = en_q && ((mode_q == TM_FREE) || (cnt_q != '0));
  assign at_one    = (cnt_q == ONE);
  assign expire    = running && at_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= TM_FREE;
    end else if (ctrl_we) begin
      en_q   <= ctrl_en;
      mode_q <= ctrl_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (cnt_we) begin
      cnt_q    <= cnt_val;
      reload_q <= cnt_val;
    end else if (running) begin
      if (expire && loop_mode) cnt_q <= reload_q;
      else                     cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= expire && !cnt_we;
  end

  // R4
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_val)));

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !at_one && !cnt_we) |=> (cnt_q == $past(cnt_q) - ONE));

  // R6
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cnt_we && !loop_mode) |=> (irq_q && cnt_q == '0));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cnt_we && loop_mode) |=> (irq_q && cnt_q == reload_q));

  // R12
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_we) |=> $stable(cnt_q));

  // R11
  no_irq_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> !irq_q);

endmodule

// File: rtl/tick_bank.sv
module tick_bank
  import tick_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int CNT_W = 32,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int ADDR_W = CH_W + STRIDE_LOG2,
  localparam int BE_W   = CNT_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [N_CH-1:0]   irq
);

  logic [N_CH-1:0]            ctrl_we;
  logic                       ctrl_en;
  logic [1:0]                 ctrl_mode;
  logic [N_CH-1:0]            cnt_we;
  logic [CNT_W-1:0]           cnt_val;
  logic [N_CH-1:0]            en_v;
  logic [N_CH-1:0][1:0]       mode_v;
  logic [N_CH-1:0][CNT_W-1:0] cnt_v;

  tick_regif #(.N_CH(N_CH), .CNT_W(CNT_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_we   (ctrl_we),
    .ctrl_en   (ctrl_en),
    .ctrl_mode (ctrl_mode),
    .cnt_we    (cnt_we),
    .cnt_val   (cnt_val),
    .rd_en     (en_v),
    .rd_mode   (mode_v),
    .rd_cnt    (cnt_v)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    tick_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (ctrl_we[c]),
      .ctrl_en   (ctrl_en),
      .ctrl_mode (ctrl_mode),
      .cnt_we    (cnt_we[c]),
      .cnt_val   (cnt_val),
      .en_q      (en_v[c]),
      .mode_q    (mode_v[c]),
      .cnt_q     (cnt_v[c]),
      .irq_q     (irq[c])
    );
  end

  // R10
  irq_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq & ~$past(en_v)) == 0);

endmodule

// File: tb/test_tick_bank.sv
module test_tick_bank;
  localparam int N_CH = 8;
  localparam int CNT_W = 32;
  localparam int ADDR_W = 6;

  typedef struct packed {
    logic [2:0]  ch;
    logic [1:0]  mode;
    logic [31:0] load;
    logic [7:0]  wait_n;
    logic [31:0] exp_cnt;
    logic [3:0]  exp_irq;
  } vec_t;

  // count decrements seen = wait_n + 1 (disable edge also counts)
  localparam vec_t VECS [8] = '{
    '{3'd0, 2'd0, 32'd10,  8'd3,  32'd6,          4'd0},
    '{3'd1, 2'd1, 32'd5,   8'd10, 32'd0,          4'd1},
    '{3'd2, 2'd2, 32'd4,   8'd5,  32'd2,          4'd1},
    '{3'd3, 2'd3, 32'd3,   8'd7,  32'd0,          4'd1},
    '{3'd4, 2'd0, 32'd2,   8'd2,  32'hFFFF_FFFF,  4'd1},
    '{3'd5, 2'd2, 32'd7,   8'd0,  32'd6,          4'd0},
    '{3'd6, 2'd1, 32'd100, 8'd19, 32'd80,         4'd0},
    '{3'd7, 2'd0, 32'd0,   8'd0,  32'hFFFF_FFFF,  4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N_CH-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;
  int irq_seen [N_CH];
  logic [31:0] rd;

  always #4 clk = ~clk;

  tick_bank i_tick_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial for (int i = 0; i < N_CH; i++) irq_seen[i] = 0;

  always @(negedge clk)
    for (int i = 0; i < N_CH; i++) if (irq[i]) irq_seen[i] = irq_seen[i] + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input int ch, input bit hi, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1'b1; bus_wr = 1'b1;
    bus_addr = {ch[2:0], hi, 2'b00}; bus_wdata = d; bus_be = be;
    @(posedge clk); @(negedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rdreg(input int ch, input bit hi, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0;
    bus_addr = {ch[2:0], hi, 2'b00};
    @(posedge clk); @(negedge clk); #1;
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); #1; end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R8 free";
      2'd1: return "R6 single";
      2'd2: return "R7 reload";
      default: return "R9 mode3";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {24'b0, irq}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rdreg(0, 1'b0, rd); check("R1 ctrl ch0", rd, 32'h0);
    rdreg(5, 1'b1, rd); check("R1 count ch5", rd, 32'h0);

    // vector table: load, enable in mode, run, freeze, read back (R5 R12)
    for (int v = 0; v < 8; v++) begin
      int ch;
      ch = int'(VECS[v].ch);
      base = irq_seen[ch];
      wr(ch, 1'b1, VECS[v].load, 4'hF);
      wr(ch, 1'b0, {26'b0, VECS[v].mode, 4'b0001}, 4'h1);
      idle(int'(VECS[v].wait_n));
      wr(ch, 1'b0, 32'h0, 4'h1);
      rdreg(ch, 1'b1, rd);
      check({mode_tag(VECS[v].mode), " R5 count"}, rd, VECS[v].exp_cnt);
      check({mode_tag(VECS[v].mode), " irq pulses"}, 32'(irq_seen[ch] - base),
            32'(VECS[v].exp_irq));
    end

    // R10 earlier channels untouched by later activity
    rdreg(0, 1'b1, rd); check("R10 ch0 count kept", rd, 32'd6);
    rdreg(3, 1'b0, rd); check("R10 ch3 ctrl", rd, 32'h0);

    // R12 frozen counter stays put
    idle(5);
    rdreg(5, 1'b1, rd); check("R12 ch5 frozen", rd, 32'd6);

    // R2 control readback and dropped bits
    wr(2, 1'b0, 32'h10, 4'h1);
    rdreg(2, 1'b0, rd); check("R2 ctrl readback", rd, 32'h10);
    wr(2, 1'b0, 32'hCE, 4'h1);
    rdreg(2, 1'b0, rd); check("R2 junk bits dropped", rd, 32'h0);

    // R3 partial strobes ignored
    wr(0, 1'b1, 32'h1234, 4'b0011);
    rdreg(0, 1'b1, rd); check("R3 narrow count write", rd, 32'd6);
    wr(1, 1'b0, 32'h11, 4'b1110);
    rdreg(1, 1'b0, rd); check("R3 ctrl without lane0", rd, 32'h0);

    // R11 load beats a count step
    wr(0, 1'b0, 32'h01, 4'h1);
    wr(0, 1'b1, 32'd50, 4'hF);
    wr(0, 1'b0, 32'h0, 4'h1);
    rdreg(0, 1'b1, rd); check("R11 load over step", rd, 32'd49);

    // R4 load while disabled, then R11 load on expiry edge
    wr(4, 1'b1, 32'd3, 4'hF);
    rdreg(4, 1'b1, rd); check("R4 load disabled", rd, 32'd3);
    base = irq_seen[4];
    wr(4, 1'b0, 32'h11, 4'h1);
    idle(2);
    wr(4, 1'b1, 32'd9, 4'hF);
    wr(4, 1'b0, 32'h0, 4'h1);
    rdreg(4, 1'b1, rd); check("R11 count after collision", rd, 32'd8);
    check("R11 no irq on collision", 32'(irq_seen[4] - base), 32'd0);

    // R7 cadence: reload 3, nine steps -> three pulses, back at 3
    wr(2, 1'b1, 32'd3, 4'hF);
    base = irq_seen[2];
    wr(2, 1'b0, 32'h21, 4'h1);
    idle(8);
    wr(2, 1'b0, 32'h0, 4'h1);
    check("R7 pulse count", 32'(irq_seen[2] - base), 32'd3);
    rdreg(2, 1'b1, rd); check("R7 count", rd, 32'd3);
    check("R10 other irq quiet", 32'(irq_seen[7]), 32'd0);

    finish_run();
  end
endmodule